// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port

This block is a small memory-mapped I/O port. Four pad pins can each be set as input or output through a direction register. Output levels come from an output data register. A pin-level register shows the synchronized state of those four pads and of four more input-only pads. A simple single-cycle bus writes and reads the three byte-wide registers. Reads are combinational from the address, and writes land on the clock edge where the write strobe is high.

The port has three reset-like controls. A synchronous active-low system reset clears both writable registers. A hardware-standby input also clears them and holds them clear. A software-standby input freezes them at their current values. Bus writes are blocked while either standby input is high. The direction register is write-only. A read of its address returns the fixed value 0xFF, so the stored direction can only be seen at the pads.

Top module: `qport_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the direction and output data registers clear to zero, so `pad_oe` and `pad_out` are 0 and a read of address 1 returns 0x00.
- R2: A write to address 0 stores `wdata[3:0]` as the direction bits, and bits 7..4 are ignored. Direction bit i equal to 1 drives `pad_oe[i]` high (output). Direction bit i equal to 0 drives it low (input).
- R3: `pad_out[i]` equals output data bit i when direction bit i is 1, and is 0 when direction bit i is 0.
- R4: A write to address 1 stores `wdata[3:0]` as output data. A read of address 1 returns {4'b0000, data}, and writes to bits 7..4 have no effect.
- R5: A read of address 0 always returns 0xFF, whatever direction value is stored.
- R6: A read of address 2 returns {`pad_extra_in`, `pad_in`} as sampled through a two-flop synchronizer. A pad change made before edge k is visible after edge k+1 and not after edge k.
- R7: Writes to address 2 and address 3 change no register. A read of address 3 returns 0x00.
- R8: While `hw_stby` is high at a clock edge, both registers clear to zero and bus writes are ignored.
- R9: While `sw_stby` is high and `hw_stby` is low, both registers keep their values and bus writes are ignored. Normal writes resume once `sw_stby` falls.
- R10: A write takes effect on the rising edge where `wr_en` is high. A read reflects the new value right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hw_stby | input | 1 | Hardware standby: clears and holds registers |
| sw_stby | input | 1 | Software standby: freezes registers |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Register address (0 direction, 1 data, 2 pin level) |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational from `addr` |
| pad_in | input | 4 | Input levels of the four bidirectional pads |
| pad_extra_in | input | 4 | Input levels of the four input-only pads |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin output value |

## Verification
The bench builds the port with its default parameters: four bidirectional pins, four input-only pins, and a two-stage synchronizer. With these values every pin-level bit sits at a fixed position in the read byte. The two-cycle input latency can then be checked edge by edge, and the reserved upper nibbles of the direction and data registers can be driven with ones to show they have no effect. Both standby inputs are exercised with stored nonzero patterns, so clearing and holding can be told apart at the pads.

// File: rtl/qport_pkg.sv
// Shared constants and the register-select type for the four-pin I/O port.
// Assumes a byte-wide bus and a two-bit register address.
package qport_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam logic [7:0] DIR_READ_VALUE = 8'hFF;
endpackage

// File: rtl/qport_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes the inputs are level signals; there is no glitch filtering.
// The output lags the input by STAGES clock edges.
module qport_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the sampled level one stage further on each edge.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

    // Count edges since reset (saturating) so the latency check only starts
    // once the chain holds real samples.
    logic [1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (run_cnt != 2'd3)
            run_cnt <= run_cnt + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk
            assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (run_cnt >= 2'd2) |-> (q == $past(d, 2)));
        end
    endgenerate
endmodule

// File: rtl/qport_regs.sv
// Direction and output-data registers with their standby behaviour.
// Assumes a single-cycle bus write: the register is updated at the edge
// where wr_en is high. Hardware standby clears the registers like reset.
// Software standby blocks writes so the contents are held.
module qport_regs
    import qport_pkg::*;
#(
    parameter int NPINS  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  data_q
);
    logic wr_ok;
    logic wr_dir;
    logic wr_data;

    // Qualify the bus strobe with both standby inputs and decode the target.
    always_comb begin
        wr_ok   = wr_en && !hw_stby && !sw_stby;
        wr_dir  = wr_ok && (reg_sel_e'(addr) == SEL_DIR);
        wr_data = wr_ok && (reg_sel_e'(addr) == SEL_DATA);
    end

    // Direction register: cleared by reset or hardware standby.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby)
            dir_q <= '0;
        else if (wr_dir)
            dir_q <= wdata[NPINS-1:0];
    end

    // Output data register: cleared by reset or hardware standby.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby)
            data_q <= '0;
        else if (wr_data)
            data_q <= wdata[NPINS-1:0];
    end

    assert_hw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dir_q == '0) && (data_q == '0));

    assert_sw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(dir_q) && $stable(data_q));

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hw_stby && !sw_stby && addr == 2'd1) |=> (data_q == $past(wdata[NPINS-1:0])));
endmodule

// File: rtl/qport_rdmux.sv
// Read-data multiplexer for the port registers.
// Assumes a combinational read: rdata follows addr in the same cycle.
// The direction register is write-only and reads as a fixed value.
module qport_rdmux
    import qport_pkg::*;
#(
    parameter int NPINS  = 4,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  data_q,
    input  logic [DATA_W-1:0] pin_lvl,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - NPINS;

    // Select the read source; the reserved data bits read as zero.
    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_DIR:  rdata = DIR_READ_VALUE;
            SEL_DATA: rdata = {{PAD_W{1'b0}}, data_q};
            SEL_PIN:  rdata = pin_lvl;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/qport_top.sv
// Four-pin general-purpose I/O port: direction and output data registers,
// pad drive, and a synchronized pin-level register that also carries the
// input-only pads in its upper bits.
// Assumes NPINS + NEXTRA equals the bus width and all pads are asynchronous.
module qport_top
    import qport_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int NEXTRA      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hw_stby,
    input  logic                     sw_stby,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NPINS+NEXTRA-1:0]  wdata,
    output logic [NPINS+NEXTRA-1:0]  rdata,
    input  logic [NPINS-1:0]         pad_in,
    input  logic [NEXTRA-1:0]        pad_extra_in,
    output logic [NPINS-1:0]         pad_oe,
    output logic [NPINS-1:0]         pad_out
);
    localparam int DATA_W = NPINS + NEXTRA;

    logic [NPINS-1:0]  dir_q;
    logic [NPINS-1:0]  data_q;
    logic [DATA_W-1:0] pin_lvl;

    qport_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    qport_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pad_extra_in, pad_in}),
        .q     (pin_lvl)
    );

    qport_rdmux #(.NPINS(NPINS), .DATA_W(DATA_W)) u_rdmux (
        .addr    (addr),
        .data_q  (data_q),
        .pin_lvl (pin_lvl),
        .rdata   (rdata)
    );

    // Pad drive: enable follows direction, value is masked for input pins.
    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_pad
            always_comb begin
                pad_oe[p]  = dir_q[p];
                pad_out[p] = dir_q[p] ? data_q[p] : 1'b0;
            end
        end
    endgenerate

    assert_idle_pad_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0) && (pad_out == '0));
endmodule

// File: tb/sim_qport_top.sv
module sim_qport_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [3:0] pad_in = 4'h0;
    logic [3:0] pad_extra_in = 4'h0;
    logic [3:0] pad_oe;
    logic [3:0] pad_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    qport_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_stby      (hw_stby),
        .sw_stby      (sw_stby),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .pad_in       (pad_in),
        .pad_extra_in (pad_extra_in),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pads_check(input string req, input logic [3:0] oe, input logic [3:0] ov);
        check8(req, {pad_oe, pad_out}, {oe, ov});
    endtask

    task automatic t_reset;
        logic [7:0] r;
        bus_read(2'd1, r);
        check8("R1 data after reset", r, 8'h00);
        pads_check("R1 pads after reset", 4'h0, 4'h0);
    endtask

    task automatic t_direction;
        bus_write(2'd1, 8'h0F);
        pads_check("R3 inputs mask data", 4'h0, 4'h0);
        bus_write(2'd0, 8'hF5);
        pads_check("R2 direction upper ignored", 4'h5, 4'h5);
        bus_write(2'd0, 8'h0A);
        pads_check("R2 direction 0A", 4'hA, 4'hA);
    endtask

    task automatic t_data;
        logic [7:0] r;
        bus_write(2'd0, 8'h0F);
        bus_write(2'd1, 8'hF6);
        bus_read(2'd1, r);
        check8("R4 data upper reads zero", r, 8'h06);
        pads_check("R3 pads follow data", 4'hF, 4'h6);
        bus_read(2'd0, r);
        check8("R5 direction reads FF", r, 8'hFF);
        bus_write(2'd0, 8'h00);
        bus_read(2'd0, r);
        check8("R5 direction reads FF when zero", r, 8'hFF);
    endtask

    task automatic t_timing;
        logic [7:0] r;
        bus_write(2'd0, 8'h0F);
        @(negedge clk);
        addr = 2'd1; wdata = 8'h09; wr_en = 1'b1;
        #1 check8("R10 no change before edge", rdata, 8'h06);
        @(posedge clk); #1;
        wr_en = 1'b0;
        check8("R10 new value after edge", rdata, 8'h09);
        bus_read(2'd1, r);
        check8("R10 value held", r, 8'h09);
    endtask

    task automatic t_pins;
        @(negedge clk);
        addr = 2'd2; pad_in = 4'h3; pad_extra_in = 4'hC;
        @(posedge clk); #1;
        check8("R6 not visible after one edge", rdata, 8'h00);
        @(posedge clk); #1;
        check8("R6 visible after two edges", rdata, 8'hC3);
        @(negedge clk);
        pad_in = 4'hA; pad_extra_in = 4'h5;
        repeat (2) @(posedge clk);
        #1 check8("R6 second pattern", rdata, 8'h5A);
    endtask

    task automatic t_ignored;
        logic [7:0] r;
        bus_write(2'd2, 8'hFF);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd1, r);
        check8("R7 data unchanged", r, 8'h09);
        pads_check("R7 pads unchanged", 4'hF, 4'h9);
        bus_read(2'd3, r);
        check8("R7 unmapped reads zero", r, 8'h00);
        bus_read(2'd2, r);
        check8("R7 pin reg still pads", r, 8'h5A);
    endtask

    task automatic t_sw_standby;
        logic [7:0] r;
        @(negedge clk); sw_stby = 1'b1;
        bus_write(2'd1, 8'h02);
        bus_write(2'd0, 8'h00);
        bus_read(2'd1, r);
        check8("R9 data held in sw standby", r, 8'h09);
        pads_check("R9 pads held in sw standby", 4'hF, 4'h9);
        @(negedge clk); sw_stby = 1'b0;
        bus_write(2'd1, 8'h0C);
        bus_read(2'd1, r);
        check8("R9 writes resume", r, 8'h0C);
    endtask

    task automatic t_hw_standby;
        logic [7:0] r;
        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk);
        pads_check("R8 pads cleared", 4'h0, 4'h0);
        bus_write(2'd1, 8'h07);
        bus_write(2'd0, 8'h0F);
        bus_read(2'd1, r);
        check8("R8 writes blocked", r, 8'h00);
        pads_check("R8 direction stays clear", 4'h0, 4'h0);
        @(negedge clk); hw_stby = 1'b0;
        bus_write(2'd0, 8'h03);
        bus_write(2'd1, 8'h01);
        pads_check("R8 recovery", 4'h3, 4'h1);
    endtask

    task automatic t_reset_again;
        logic [7:0] r;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(2'd1, r);
        check8("R1 data after second reset", r, 8'h00);
        pads_check("R1 pads after second reset", 4'h0, 4'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_data();
        t_timing();
        t_pins();
        t_ignored();
        t_sw_standby();
        t_hw_standby();
        t_reset_again();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule